// File: doc/BRIEF.md
# Coalescing Output Line Buffer

This block sits between a processor that emits text one character at a time and a link engine that carries transactions to a remote console. Characters are not forwarded one by one. They are gathered in a local store, and the whole run is handed over as a single print transaction. This keeps the number of link transactions low.

A run is closed in three cases. The first is a write that carries an end-of-line mark. The second is the write that fills the store to its last slot. The third is the processor asking to issue some unrelated command while characters are still waiting. In every case the link engine sees a flush request with the exact byte count and drains the bytes in write order through a pop port. The writer is stalled until the last byte has been popped. A command request is granted only once the store is empty.

Top module: `linebuf_coalescer`

## Requirements
- R1: After reset, `flush_req` and `cmd_grant` are low and, with `cmd_req` low, `wr_ready` is high.
- R2: A write accepted without `wr_eol` that leaves fewer than DEPTH (128) bytes stored raises no flush; `wr_ready` stays high.
- R3: An accepted write with `wr_eol` high stores that byte, and from the next cycle `flush_req` is high with `flush_count` equal to the run length including that byte.
- R4: The write that makes the stored count reach DEPTH raises `flush_req` in the next cycle with `flush_count` equal to DEPTH; `flush_count` is an unsigned binary count of clog2(DEPTH+1) bits.
- R5: When `cmd_req` is raised with at least one byte stored, the buffer is flushed first, and `cmd_grant` stays low until the drain has completed.
- R6: When `cmd_req` is high and the buffer is empty and idle, `cmd_grant` is high in the same cycle and no flush is raised.
- R7: `wr_eol` with `wr_valid` low is ignored: it raises no flush and leaves the stored run unchanged.
- R8: While `flush_req` is high, `wr_ready` is low and any `wr_valid` is ignored; no such byte appears in any later run.
- R9: During a flush, `rd_data` shows the stored bytes in the order they were written, advancing by one on each cycle with `rd_pop` high. `rd_last` is high exactly for the final byte. After that byte is popped, `flush_req` is low in the next cycle.
- R10: While `flush_req` is high, `flush_count` lies between 1 and DEPTH and does not change.
- R11: While `cmd_req` is high, `wr_ready` is low and no write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Character write strobe |
| wr_data | input | DATA_W | Character byte |
| wr_eol | input | 1 | This write ends the line; meaningful only with wr_valid |
| wr_ready | output | 1 | Writer may proceed; a write is taken when wr_valid and wr_ready are both high |
| cmd_req | input | 1 | Processor wants to issue another command |
| cmd_grant | output | 1 | Buffer is empty; the command may go out |
| flush_req | output | 1 | A flush-and-print transaction is pending |
| flush_count | output | clog2(DEPTH+1) | Number of bytes in the pending transaction |
| rd_pop | input | 1 | Link engine consumes rd_data |
| rd_data | output | DATA_W | Current byte of the run being drained |
| rd_last | output | 1 | rd_data is the final byte of the run |

## Verification
The coalescing function is tried with short lines closed by an end-of-line byte, with bare end-of-line pulses that carry no data, with an exactly full run, and with an overlong stream that first fills the store and then leaves a short tail. Each pattern closes a run by a different trigger. Comparing the flush count and the byte order of each run with a queued reference shows whether the right trigger fired and whether the correct boundary was used. Command requests are made both when the buffer is empty and when it holds data. This separates an immediate grant from a grant that has to wait for the flush. Writes attempted during a drain are followed by a one-byte run, which shows whether any of those writes slipped into the store.

// File: rtl/lbc_pkg.sv
package lbc_pkg;

  typedef enum logic {
    LBC_FILL  = 1'b0,
    LBC_FLUSH = 1'b1
  } lbc_state_e;

  // Stored count after a cycle in which a write may have been taken.
  function automatic int unsigned f_count_after(int unsigned cnt, bit take);
    return cnt + (take ? 1 : 0);
  endfunction

  // A run must close when the store has no free slot left.
  function automatic bit f_run_full(int unsigned cnt, int unsigned depth);
    return cnt == depth;
  endfunction

  // Index of the final byte of a run of the given length.
  function automatic int unsigned f_last_index(int unsigned cnt);
    return (cnt == 0) ? 0 : cnt - 1;
  endfunction

endpackage

// File: rtl/lbc_store.sv
module lbc_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 128,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx];

endmodule

// File: rtl/lbc_ctrl.sv
module lbc_ctrl
  import lbc_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic          wr_eol,
  input  logic          cmd_req,
  input  logic          rd_pop,
  output logic          wr_ready,
  output logic          cmd_grant,
  output logic          flush_req,
  output logic [CW-1:0] flush_count,
  output logic          rd_last,
  output logic          wr_take,
  output logic [AW-1:0] wr_idx,
  output logic [AW-1:0] rd_idx,
  output logic          flush_start,
  output logic          drain_done
);

  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  lbc_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] rd_q;
  logic [CW-1:0] cnt_after;
  logic          close_eol, close_full, close_cmd;
  logic          drain_step;
  logic          filling;

  assign filling   = (state_q == LBC_FILL);
  assign wr_ready  = filling && !cmd_req;
  assign wr_take   = wr_valid && wr_ready;
  assign wr_idx    = cnt_q[AW-1:0];
  assign cnt_after = CW'(f_count_after(int'(cnt_q), wr_take));

  assign close_eol   = wr_take && wr_eol;
  assign close_full  = wr_take && f_run_full(int'(cnt_after), DEPTH);
  assign close_cmd   = filling && cmd_req && (cnt_q != '0);
  assign flush_start = close_eol || close_full || close_cmd;

  assign cmd_grant   = filling && cmd_req && (cnt_q == '0);

  assign flush_req   = (state_q == LBC_FLUSH);
  assign flush_count = cnt_q;
  assign rd_idx      = rd_q;
  assign rd_last     = flush_req && (CW'(rd_q) == CW'(f_last_index(int'(cnt_q))));
  assign drain_step  = flush_req && rd_pop;
  assign drain_done  = drain_step && rd_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= LBC_FILL;
      cnt_q   <= '0;
      rd_q    <= '0;
    end else begin
      unique case (state_q)
        LBC_FILL: begin
          cnt_q <= cnt_after;
          rd_q  <= '0;
          if (flush_start) state_q <= LBC_FLUSH;
        end
        LBC_FLUSH: begin
          if (drain_done) begin
            state_q <= LBC_FILL;
            cnt_q   <= '0;
            rd_q    <= '0;
          end else if (drain_step) begin
            rd_q <= rd_q + AW'(1);
          end
        end
        default: state_q <= LBC_FILL;
      endcase
    end
  end

  // R3: an end-of-line write opens a flush whose count includes that byte
  p_eol_flush_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_take && wr_eol) |=> (flush_req && flush_count == $past(cnt_q) + CW'(1)));

  // R4: the write that fills the store opens a full-size flush
  p_full_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_take && cnt_q == DEPTH_C - CW'(1)) |=> (flush_req && flush_count == DEPTH_C));

  // R5: no grant while a flush is still in progress
  p_no_grant_in_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> !cmd_grant);

  // R8: the writer is stalled during a drain
  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> !wr_ready);

  // R9: popping the final byte ends the flush in the next cycle
  p_drain_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req && rd_pop && rd_last) |=> !flush_req);

  // R10: count lies in range during a flush
  p_count_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> (flush_count != '0 && flush_count <= DEPTH_C));

  // R10: count holds steady for the whole flush
  p_count_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req && $past(flush_req)) |-> $stable(flush_count));

  // R11: no write is taken while a command is requested
  p_no_take_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req |-> !wr_take);

endmodule

// File: rtl/linebuf_coalescer.sv
module linebuf_coalescer #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 128,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_eol,
  output logic              wr_ready,
  input  logic              cmd_req,
  output logic              cmd_grant,
  output logic              flush_req,
  output logic [CW-1:0]     flush_count,
  input  logic              rd_pop,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_last
);

  // Internal events brought out for checking.
  logic          ev_wr_take;
  logic          ev_flush_start;
  logic          ev_drain_done;
  logic [AW-1:0] st_wr_idx;
  logic [AW-1:0] st_rd_idx;

  lbc_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid    (wr_valid),
    .wr_eol      (wr_eol),
    .cmd_req     (cmd_req),
    .rd_pop      (rd_pop),
    .wr_ready    (wr_ready),
    .cmd_grant   (cmd_grant),
    .flush_req   (flush_req),
    .flush_count (flush_count),
    .rd_last     (rd_last),
    .wr_take     (ev_wr_take),
    .wr_idx      (st_wr_idx),
    .rd_idx      (st_rd_idx),
    .flush_start (ev_flush_start),
    .drain_done  (ev_drain_done)
  );

  lbc_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .wr_en   (ev_wr_take),
    .wr_idx  (st_wr_idx),
    .wr_data (wr_data),
    .rd_idx  (st_rd_idx),
    .rd_data (rd_data)
  );

  // R1/R9: a flush only begins from idle and only ends from a flush
  p_start_from_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_flush_start |-> !flush_req);

  p_done_in_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drain_done |-> flush_req);

  // R7: an end-of-line mark without a write never starts a flush by itself
  p_bare_eol_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_eol && !wr_valid && !cmd_req && !flush_req) |-> !ev_flush_start);

endmodule

// File: tb/linebuf_coalescer_tb.sv
`timescale 1ns/1ps
module linebuf_coalescer_tb;

  localparam int DATA_W = 8;
  localparam int DEPTH  = 128;
  localparam int CW     = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_valid = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              wr_eol = 1'b0;
  logic              wr_ready;
  logic              cmd_req = 1'b0;
  logic              cmd_grant;
  logic              flush_req;
  logic [CW-1:0]     flush_count;
  logic              rd_pop = 1'b0;
  logic [DATA_W-1:0] rd_data;
  logic              rd_last;

  always #2.5 clk = ~clk;

  linebuf_coalescer #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_eol(wr_eol), .wr_ready(wr_ready),
    .cmd_req(cmd_req), .cmd_grant(cmd_grant),
    .flush_req(flush_req), .flush_count(flush_count),
    .rd_pop(rd_pop), .rd_data(rd_data), .rd_last(rd_last)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // Scoreboard state
  logic [DATA_W-1:0] mdl[$];
  logic [DATA_W-1:0] exp_bytes[$];
  int                exp_cnt[$];
  bit                in_flush = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void close_run();
    if (mdl.size() != 0) begin
      exp_cnt.push_back(mdl.size());
      foreach (mdl[i]) exp_bytes.push_back(mdl[i]);
      mdl.delete();
    end
  endfunction

  // Driver: one character write, waits out stalls.
  task automatic put(input logic [DATA_W-1:0] d, input bit eol);
    do begin
      @(negedge clk); #1;
    end while (!wr_ready);
    wr_valid = 1'b1; wr_data = d; wr_eol = eol;
    @(posedge clk); #1;
    wr_valid = 1'b0; wr_eol = 1'b0;
    mdl.push_back(d);
    if (eol || mdl.size() == DEPTH) close_run();
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (flush_req || in_flush || exp_cnt.size() != 0);
    @(negedge clk);
  endtask

  task automatic quiet(input int cycles, input string req);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check(flush_req == 1'b0, req, "flush_req stays low", flush_req, 0);
    end
  endtask

  task automatic do_cmd();
    bit had_data;
    int guard;
    had_data = (mdl.size() != 0);
    @(negedge clk);
    cmd_req = 1'b1; #1;
    check(wr_ready == 1'b0, "R11", "wr_ready while cmd_req", wr_ready, 0);
    if (had_data) begin
      close_run();
      check(cmd_grant == 1'b0, "R5", "grant with data pending", cmd_grant, 0);
      guard = 0;
      while (!cmd_grant && guard < 2000) begin
        @(negedge clk); #1; guard++;
      end
      check(cmd_grant == 1'b1, "R5", "grant after flush", cmd_grant, 1);
      check(exp_cnt.size() == 0 && !flush_req, "R5", "flush drained before grant",
            exp_cnt.size(), 0);
    end else begin
      check(cmd_grant == 1'b1, "R6", "immediate grant on empty", cmd_grant, 1);
      @(negedge clk); #1;
      check(flush_req == 1'b0, "R6", "no flush on empty cmd", flush_req, 0);
    end
    @(posedge clk); #1;
    cmd_req = 1'b0;
  endtask

  // Monitor: drains flushes every other cycle and compares.
  initial begin
    bit phase;
    bit just_done;
    int remaining;
    phase = 0; just_done = 0; remaining = 0;
    forever begin
      @(negedge clk);
      if (just_done) begin
        check(flush_req == 1'b0, "R9", "flush_req after last pop", flush_req, 0);
        just_done = 0;
      end
      if (rst_n && flush_req) begin
        if (!in_flush) begin
          in_flush = 1; phase = 0;
          if (exp_cnt.size() == 0) begin
            check(1'b0, "R2", "unexpected flush count", flush_count, 0);
            remaining = flush_count;
            for (int i = 0; i < remaining; i++) exp_bytes.push_front('0);
          end else begin
            remaining = exp_cnt.pop_front();
            check(flush_count == CW'(remaining), "R3", "flush_count", flush_count, remaining);
          end
        end
        check(wr_ready == 1'b0, "R8", "wr_ready during flush", wr_ready, 0);
        if (phase && remaining > 0) begin
          logic [DATA_W-1:0] e;
          e = exp_bytes.pop_front();
          check(rd_data == e, "R9", "rd_data order", rd_data, e);
          check(rd_last == (remaining == 1), "R9", "rd_last", rd_last, remaining == 1);
          rd_pop = 1'b1;
          remaining--;
          if (remaining == 0) just_done = 1;
        end else begin
          rd_pop = 1'b0;
        end
        phase = !phase;
      end else begin
        rd_pop = 1'b0;
        in_flush = 0;
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1: reset state
    check(flush_req == 1'b0, "R1", "flush_req after reset", flush_req, 0);
    check(cmd_grant == 1'b0, "R1", "cmd_grant after reset", cmd_grant, 0);
    check(wr_ready == 1'b1, "R1", "wr_ready after reset", wr_ready, 1);

    // R2: plain writes accumulate without a flush
    put(8'h48, 0);
    put(8'h69, 0);
    @(negedge clk); #1;
    check(wr_ready == 1'b1, "R2", "wr_ready while filling", wr_ready, 1);
    quiet(4, "R2");
    // R3: end-of-line byte closes the run including itself
    put(8'h0A, 1);
    wait_idle();

    // R7: bare end-of-line pulses on empty and partial buffers
    @(negedge clk); wr_eol = 1'b1; @(posedge clk); #1; wr_eol = 1'b0;
    quiet(3, "R7");
    put(8'h31, 0);
    put(8'h32, 0);
    @(negedge clk); wr_eol = 1'b1; @(posedge clk); #1; wr_eol = 1'b0;
    quiet(3, "R7");
    put(8'h33, 1);           // run of 3 shows the pulses changed nothing
    wait_idle();

    // R8: writes during a drain are dropped
    put(8'h41, 0);
    put(8'h42, 1);
    @(negedge clk); #1;
    check(flush_req == 1'b1 && wr_ready == 1'b0, "R8", "stall at flush start", wr_ready, 0);
    wr_valid = 1'b1; wr_data = 8'hEE;
    repeat (2) @(negedge clk);
    wr_valid = 1'b0;
    wait_idle();
    put(8'h5A, 1);           // one-byte run proves 0xEE was not stored
    wait_idle();

    // R4: exactly full run
    for (int i = 0; i < DEPTH; i++) put(8'(i * 3 + 1), 0);
    wait_idle();

    // R4 then R5: overlong stream, tail flushed ahead of a command
    for (int i = 0; i < DEPTH + 2; i++) put(8'(255 - i), 0);
    do_cmd();
    wait_idle();

    // R6: command on empty buffer
    do_cmd();

    // R5: command with a short pending run
    put(8'h70, 0);
    do_cmd();
    wait_idle();

    check(exp_cnt.size() == 0 && exp_bytes.size() == 0, "R9", "scoreboard empty",
          exp_bytes.size(), 0);
    finish_run();
  end

endmodule